// File: doc/BRIEF.md
# Pulse-Domain Node Control Injector

This block is a test-access cell placed between two stages of pulse-encoded logic, for example between two slices of a bit-serial adder. In these stages a logic one is carried as a single-cycle pulse. The cell lets a tester overrule what the upstream stage hands on. The upstream pulse does not travel straight through. It is caught in a gating store that only lets it go when the control strobe fires, so holding the strobe low cuts off the normal data. A separate test level input, driven by an ordinary bit or word generator, is turned into one pulse per rising edge. A merger joins the released upstream pulse and the injected pulse into the single stream that feeds the next stage.

Gating store and merger together behave as a two-way selector. With the strobe applied every cycle and the test level held low, the cell adds exactly one cycle of delay to the upstream stream. With the strobe withheld, only injected pulses reach the output. With both in use, the two sources are interleaved, and any collision is spread over consecutive cycles.

Three small state machines carry the behaviour:
- The edge pulser has states LVL_LOW and LVL_HIGH. It moves LVL_LOW→LVL_HIGH on a high level, which emits a pulse. It moves LVL_HIGH→LVL_LOW on a low level, which is silent.
- The gating store has states STORE_EMPTY and STORE_FULL:
  - EMPTY→FULL on an upstream pulse without the strobe.
  - FULL→EMPTY on the strobe with no new upstream pulse.
  - FULL→FULL on the strobe together with a new pulse, which releases the old pulse and keeps the new one.
  - FULL→FULL on a pulse without the strobe, which absorbs the new pulse.
- The merger has states MRG_IDLE and MRG_PENDING. It goes IDLE→PENDING when two pulses meet. It goes PENDING→IDLE when the held pulse drains with no other arrival.

Top module: `pulse_node_injector`

## Requirements
- R1: A rising edge of `test_level` gives exactly one `dn_pulse`, in the cycle after the edge is sampled, provided no other pulse competes.
- R2: A falling edge of `test_level`, or the level held high, produces no pulse.
- R3: An upstream pulse taken while `ctl_strobe` is low gives no output. It is held in the gating store until a strobe comes.
- R4: A strobe with the store full and no new upstream pulse releases the held pulse. `dn_pulse` goes high one cycle later and the store empties, so a further strobe produces nothing.
- R5: A second upstream pulse that arrives while the store is full and the strobe is low is absorbed. A later strobe releases only one pulse.
- R6: An upstream pulse with the strobe high and the store empty passes through. `dn_pulse` is high one cycle later, so a strobe held high every cycle gives the upstream stream delayed by one cycle.
- R7: A strobe that arrives with the store full and a new upstream pulse releases the held pulse and keeps the new pulse stored.
- R8: When a released pulse and an injected pulse meet in the same cycle with nothing pending, `dn_pulse` is high on two consecutive cycles.
- R9: The merger holds at most one extra pulse. If three pulses compete (pending, released, injected), one is output, one stays pending and the third is lost.
- R10: Reset (active-low `rst_n`, asynchronous) clears the output, the store and the pending pulse, and treats the test level as low. A level already high when reset is released therefore counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_pulse | input | 1 | Pulse from the previous stage |
| ctl_strobe | input | 1 | Control strobe that releases the gated upstream pulse |
| test_level | input | 1 | Level from the test bit generator |
| dn_pulse | output | 1 | Pulse to the next stage, registered |

## Verification
Every result appears exactly one clock after the inputs that cause it are sampled, because the only register on any path to `dn_pulse` is the merger output register. A collision adds one further cycle for the pending pulse. A held upstream pulse is due one cycle after the strobe that releases it. The bench drives inputs at the falling edge, lets one rising edge pass, and compares `dn_pulse` at the next falling edge. Hand-computed values are used for the directed cases, and a cycle-level arithmetic model is used for a long pseudo-random sweep of all input combinations.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic {LVL_LOW, LVL_HIGH} lvl_state_t;
    typedef enum logic {STORE_EMPTY, STORE_FULL} store_state_t;
    typedef enum logic {MRG_IDLE, MRG_PENDING} mrg_state_t;
endpackage

// File: rtl/pic_edge_pulser.sv
module pic_edge_pulser
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    lvl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pulse_o = 1'b0;
        unique case (state_q)
            LVL_LOW: if (level_i) begin
                state_d = LVL_HIGH;
                pulse_o = 1'b1;
            end
            LVL_HIGH: if (!level_i) state_d = LVL_LOW;
        endcase
    end
endmodule

// File: rtl/pic_gate_store.sv
module pic_gate_store
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic strobe_i,
    output logic rel_o,
    output logic full_o
);
    store_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STORE_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rel_o   = 1'b0;
        unique case (state_q)
            STORE_EMPTY: begin
                if (up_i && strobe_i) rel_o = 1'b1;
                else if (up_i)        state_d = STORE_FULL;
            end
            STORE_FULL: begin
                if (strobe_i) begin
                    rel_o = 1'b1;
                    if (!up_i) state_d = STORE_EMPTY;
                end
            end
        endcase
    end

    assign full_o = (state_q == STORE_FULL);
endmodule

// File: rtl/pic_merger.sv
module pic_merger
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic out_o,
    output logic pend_o
);
    mrg_state_t state_q, state_d;
    logic       out_q, out_d;
    logic [1:0] arrivals;

    assign arrivals = {1'b0, a_i} + {1'b0, b_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MRG_IDLE;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    always_comb begin
        state_d = state_q;
        out_d   = 1'b0;
        unique case (state_q)
            MRG_IDLE: begin
                out_d = (arrivals != 2'd0);
                if (arrivals == 2'd2) state_d = MRG_PENDING;
            end
            MRG_PENDING: begin
                out_d = 1'b1;
                if (arrivals == 2'd0) state_d = MRG_IDLE;
            end
        endcase
    end

    assign out_o  = out_q;
    assign pend_o = (state_q == MRG_PENDING);
endmodule

// File: rtl/pulse_node_injector.sv
module pulse_node_injector (
    input  logic clk,
    input  logic rst_n,
    input  logic up_pulse,
    input  logic ctl_strobe,
    input  logic test_level,
    output logic dn_pulse
);
    logic injected;
    logic gated;
    logic store_full;
    logic merge_pend;

    pic_edge_pulser u_pulser (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (test_level),
        .pulse_o (injected)
    );

    pic_gate_store u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (up_pulse),
        .strobe_i (ctl_strobe),
        .rel_o    (gated),
        .full_o   (store_full)
    );

    pic_merger u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (gated),
        .b_i    (injected),
        .out_o  (dn_pulse),
        .pend_o (merge_pend)
    );
endmodule

// File: rtl/pulse_node_injector_chk.sv
module pulse_node_injector_chk (
    input logic clk,
    input logic rst_n,
    input logic up_pulse,
    input logic ctl_strobe,
    input logic test_level,
    input logic dn_pulse,
    input logic injected,
    input logic gated,
    input logic store_full,
    input logic merge_pend
);
    p_inj_on_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        injected |-> test_level);
    p_inj_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        injected |=> !injected);
    p_gate_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gated |-> ctl_strobe);
    p_store_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (store_full && !ctl_strobe) |=> store_full);
    p_pass_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strobe && up_pulse) |=> dn_pulse);
    p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && injected && !merge_pend) |=> (dn_pulse && merge_pend));
    p_out_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_pulse |-> $past(gated || injected || merge_pend));
endmodule

bind pulse_node_injector pulse_node_injector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_pulse   (up_pulse),
    .ctl_strobe (ctl_strobe),
    .test_level (test_level),
    .dn_pulse   (dn_pulse),
    .injected   (injected),
    .gated      (gated),
    .store_full (store_full),
    .merge_pend (merge_pend)
);

// File: tb/pulse_node_injector_tb.sv
module pulse_node_injector_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_pulse = 1'b0;
    logic ctl_strobe = 1'b0;
    logic test_level = 1'b0;
    logic dn_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state
    bit m_lvl, m_held, m_pend, m_out;

    always #4 clk = ~clk;

    pulse_node_injector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_pulse   (up_pulse),
        .ctl_strobe (ctl_strobe),
        .test_level (test_level),
        .dn_pulse   (dn_pulse)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dn_pulse=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up_pulse = 1'b0; ctl_strobe = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_lvl = 0; m_held = 0; m_pend = 0; m_out = 0;
        check(dn_pulse, 1'b0, "R10 reset output");
        rst_n = 1'b1;
    endtask

    // apply one cycle of inputs, advance the model, compare after the edge
    task automatic step(input bit up, input bit con, input bit lvl,
                        input bit use_exp, input bit exp, input string tag);
        bit inj, g;
        int cnt;
        up_pulse = up; ctl_strobe = con; test_level = lvl;
        inj = lvl && !m_lvl;
        g = con && (m_held || up);
        m_held = con ? (m_held && up) : (m_held || up);
        m_lvl = lvl;
        cnt = int'(g) + int'(inj) + int'(m_pend);
        m_out = (cnt != 0);
        m_pend = (cnt >= 2);
        @(posedge clk);
        @(negedge clk);
        check(dn_pulse, use_exp ? exp : m_out, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr;
        test_level = 1'b0;
        do_reset();
        // R6 pass-through
        step(1,1,0,1,1,"R6 pass");
        step(0,1,0,1,0,"R6 pass");
        step(1,1,0,1,1,"R6 pass");
        step(1,1,0,1,1,"R6 pass back-to-back");
        // R3 hold, R5 absorb, R4 release once
        step(1,0,0,1,0,"R3 held no output");
        step(0,0,0,1,0,"R3 held no output");
        step(1,0,0,1,0,"R5 second pulse absorbed");
        step(0,1,0,1,1,"R4 release");
        step(0,1,0,1,0,"R4 store cleared");
        // R7 release and restore
        step(1,0,0,1,0,"R7 store");
        step(1,1,0,1,1,"R7 release old");
        step(0,1,0,1,1,"R7 new pulse kept");
        step(0,1,0,1,0,"R7 empty");
        // R1 / R2 injection
        step(0,0,1,1,1,"R1 rising edge");
        step(0,0,1,1,0,"R2 level held high");
        step(0,0,0,1,0,"R2 falling edge");
        step(0,0,0,1,0,"R2 quiet");
        // R8 collision
        step(1,1,1,1,1,"R8 collision first");
        step(0,0,1,1,1,"R8 collision second");
        step(0,0,0,1,0,"R8 drained");
        // R9 saturation
        step(1,1,1,1,1,"R9 collide");
        step(1,1,0,1,1,"R9 pending kept");
        step(1,1,1,1,1,"R9 three compete");
        step(0,0,1,1,1,"R9 one pending left");
        step(0,0,0,1,0,"R9 third lost");
        // R10 level high across reset release
        test_level = 1'b1;
        do_reset();
        step(0,0,1,1,1,"R10 level high after reset");
        step(0,0,0,1,0,"R10 quiet");
        // sweep: all input combinations in pseudo-random order
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 2000)
                step(lfsr[0], 1'b1, 1'b0, 0, 0, "R6 sweep strobe always");
            else if (i < 4000)
                step(lfsr[0], 1'b0, lfsr[3] & lfsr[1], 0, 0, "R3 sweep strobe withheld");
            else
                step(lfsr[0], lfsr[2], lfsr[5], 0, 0, "R9 sweep combined");
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule